// File: doc/BRIEF.md
# Four-Lane 7:1 Word Serializer with Forwarded Frame Clock

This block takes one 28-bit word per word period and splits it into four 7-bit slices. Each slice goes out on its own serial lane, one bit per bit clock. A fifth lane repeats a fixed 7-slot pattern at the word rate. The receiver uses that pattern to find word boundaries and to recover the word clock. Everything runs on the bit clock, which is seven times the word rate. A one-cycle `word_tick` pulse, asserted every seventh bit clock, marks each word boundary.

The block also models the transmitter's power and lock behaviour. Driving `pwr_n` low forces every lane low and drops `lanes_oe`, the flag that stands in for the pad tri-state control. Once `pwr_n` returns high, the block waits a parameterised number of word ticks before enabling the lanes, which models the time a PLL needs to settle. Enable always begins on a word boundary, so the first visible frame is complete.

Top module: `lane_serializer_7to1`

## Requirements
- R1: On a bit-clock edge where `word_tick` and `pwr_n` are both high, the word on `word_in` is captured into a holding register. On edges where `pwr_n` is low, the holding register keeps its value.
- R2: Lane L carries bits 7L to 7L+6 of the captured word, in that order. Bit 7L goes in slot 0 and bit 7L+6 in slot 6.
- R3: After a load edge, slot k of every lane is driven for exactly one bit clock, the k-th clock after that edge (k = 0..6). Slots are sent in increasing index order.
- R4: While enabled, the frame clock lane outputs 1,1,1,1,0,0,0 in slots 0 to 6. It is therefore high on the cycle right after each load edge and low on the cycle in which `word_tick` is high.
- R5: An edge that samples `pwr_n` low clears `lanes_oe` and forces all four data lanes and the clock lane to 0 from the next cycle onward. It also restarts the lock wait.
- R6: After `pwr_n` goes high, `lanes_oe` rises at the LOCK_WORDS-th word tick sampled with `pwr_n` high, and at no other edge. That edge is also a load edge, so slot 0 of a fresh frame is the first bit shown.
- R7: A word captured at word tick n starts leaving on the lanes at word tick n+1. This gives one word period of latency.
- R8: A synchronous active-high `rst` clears the holding register, the shift registers and the lock state. The cycle after a reset edge shows `lanes_oe` = 0 and all lanes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| word_tick | input | 1 | One-cycle pulse marking each word boundary, every seventh clock |
| pwr_n | input | 1 | Active-low powerdown |
| word_in | input | 28 | Parallel word, sampled on word ticks |
| lane_out | output | 4 | Serial data lanes, bit L is lane L |
| frame_clk | output | 1 | Forwarded frame clock lane |
| lanes_oe | output | 1 | Output-enable flag standing in for the pad tri-state |

## Verification
The hardest case to reach from the ports is a powerdown that lands partway through a frame, followed by relocking. The lanes must go quiet at once. The lock count must restart from zero, and the first enabled frame must still start at slot 0 and carry the word captured one tick earlier. The stimulus drops `pwr_n` on the fourth bit clock of a frame, holds it low across whole frames, and then releases it. It also applies a reset between frames. In both cases the bench's scoreboard recomputes the expected enable edge and the frame contents from the tick and power history.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  // Number of leading slots held high on the frame clock lane
  function automatic int clk_high_slots(input int slots);
    return (slots + 1) / 2;
  endfunction
endpackage

// File: rtl/word_capture.sv
module word_capture #(
  parameter int WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/slot_shifter.sv
module slot_shifter #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SLOTS-1:0] load_val,  // MSB is slot 0
  output logic             ser
);
  logic [SLOTS-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (load) sreg <= load_val;
    else           sreg <= {sreg[SLOTS-2:0], 1'b0};
  end

  assign ser = sreg[SLOTS-1];
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LOCK_WORDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_n,
  input  logic tick,
  output logic enabled
);
  localparam int CNT_W = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_WORDS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_n) begin
      cnt     <= '0;
      enabled <= 1'b0;
    end else if (tick && !enabled) begin
      if (cnt == LAST) enabled <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lane_serializer_7to1.sv
module lane_serializer_7to1 #(
  parameter int LANES      = 4,
  parameter int SLOTS      = 7,
  parameter int LOCK_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     word_tick,
  input  logic                     pwr_n,
  input  logic [LANES*SLOTS-1:0]   word_in,
  output logic [LANES-1:0]         lane_out,
  output logic                     frame_clk,
  output logic                     lanes_oe
);
  import serlink_pkg::*;

  localparam int WORD_W = LANES * SLOTS;
  localparam int CLK_HI = clk_high_slots(SLOTS);

  logic [WORD_W-1:0]            held;
  logic [LANES-1:0][SLOTS-1:0]  lane_ld;
  logic [SLOTS-1:0]             clk_ld;
  logic [LANES-1:0]             lane_ser;
  logic                         clk_ser;

  word_capture #(.WORD_W(WORD_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap_en (word_tick & pwr_n),
    .d      (word_in),
    .q      (held)
  );

  lock_timer #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .pwr_n   (pwr_n),
    .tick    (word_tick),
    .enabled (lanes_oe)
  );

  // Slot k of a lane sits at shift position SLOTS-1-k
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign clk_ld[SLOTS-1-k] = (k < CLK_HI);
    for (genvar l = 0; l < LANES; l++) begin : g_bit
      assign lane_ld[l][SLOTS-1-k] = held[l*SLOTS + k];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    slot_shifter #(.SLOTS(SLOTS)) u_sh (
      .clk      (clk),
      .rst      (rst),
      .load     (word_tick),
      .load_val (lane_ld[l]),
      .ser      (lane_ser[l])
    );
    assign lane_out[l] = lane_ser[l] & lanes_oe;
  end

  slot_shifter #(.SLOTS(SLOTS)) u_clk_sh (
    .clk      (clk),
    .rst      (rst),
    .load     (word_tick),
    .load_val (clk_ld),
    .ser      (clk_ser)
  );

  assign frame_clk = clk_ser & lanes_oe;
endmodule

// File: rtl/lane_serializer_checker.sv
module lane_serializer_checker #(
  parameter int LANES      = 4,
  parameter int SLOTS      = 7,
  parameter int LOCK_WORDS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             word_tick,
  input logic             pwr_n,
  input logic [LANES-1:0] lane_out,
  input logic             frame_clk,
  input logic             lanes_oe
);
  localparam int CW = $clog2(LOCK_WORDS + 1);

  // Ticks seen with power on and outputs still off
  logic [CW-1:0] ticks_seen;
  always_ff @(posedge clk) begin
    if (rst || !pwr_n)
      ticks_seen <= '0;
    else if (word_tick && !lanes_oe && ticks_seen < CW'(LOCK_WORDS))
      ticks_seen <= ticks_seen + 1'b1;
  end

  // R8
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!lanes_oe && lane_out == '0 && !frame_clk));

  // R5
  a_r5_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> (!lanes_oe && lane_out == '0 && !frame_clk));

  // R6
  a_r6_lock_count: assert property (@(posedge clk) disable iff (rst)
    $rose(lanes_oe) |-> (ticks_seen == CW'(LOCK_WORDS)));

  // R6
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(lanes_oe) |-> ($past(word_tick) && $past(pwr_n)));

  // R4
  a_r4_clk_slot0_high: assert property (@(posedge clk) disable iff (rst)
    (lanes_oe && $past(word_tick)) |-> frame_clk);

  // R4
  a_r4_clk_last_slot_low: assert property (@(posedge clk) disable iff (rst)
    (lanes_oe && word_tick) |-> !frame_clk);
endmodule

bind lane_serializer_7to1 lane_serializer_checker #(
  .LANES(LANES), .SLOTS(SLOTS), .LOCK_WORDS(LOCK_WORDS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_tick (word_tick),
  .pwr_n     (pwr_n),
  .lane_out  (lane_out),
  .frame_clk (frame_clk),
  .lanes_oe  (lanes_oe)
);

// File: tb/lane_serializer_7to1_tb.sv
module lane_serializer_7to1_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int SLOTS      = 7;
  localparam int LOCK_WORDS = 4;
  localparam int WORD_W     = LANES * SLOTS;

  logic              clk = 1'b0;
  logic              rst;
  logic              word_tick;
  logic              pwr_n;
  logic [WORD_W-1:0] word_in;
  logic [LANES-1:0]  lane_out;
  logic              frame_clk;
  logic              lanes_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [WORD_W-1:0] sb_q[$];
  logic [WORD_W-1:0] cur;
  bit                exp_en;
  int                lock_cnt;
  int                slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_serializer_7to1 #(
    .LANES(LANES), .SLOTS(SLOTS), .LOCK_WORDS(LOCK_WORDS)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .word_tick (word_tick),
    .pwr_n     (pwr_n),
    .word_in   (word_in),
    .lane_out  (lane_out),
    .frame_clk (frame_clk),
    .lanes_oe  (lanes_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // Driver: one word frame, tick on the first bit clock; pd_at drops power at that slot
  task automatic send_word(input logic [WORD_W-1:0] w, input int pd_at);
    for (int c = 0; c < SLOTS; c++) begin
      @(posedge clk); #1;
      word_tick = (c == 0);
      if (c == 0) word_in = w;
      if (c == pd_at) pwr_n = 1'b0;
    end
  endtask

  task automatic do_reset(input int cycles);
    @(posedge clk); #1;
    word_tick = 1'b0;
    rst = 1'b1;
    repeat (cycles) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Monitor / scoreboard: model at each edge, compare at the following negedge
  initial begin
    bit t, p, r;
    logic [WORD_W-1:0] d;
    cur = '0; exp_en = 1'b0; lock_cnt = 0; slot = SLOTS;
    forever begin
      @(posedge clk);
      t = word_tick; p = pwr_n; r = rst; d = word_in;
      if (r) begin
        sb_q.delete(); cur = '0; exp_en = 1'b0; lock_cnt = 0; slot = SLOTS;
      end else begin
        if (t) begin
          if (sb_q.size() > 0) cur = sb_q.pop_front();
          slot = 0;
          if (p) sb_q.push_back(d);              // R1 capture
        end else if (slot < SLOTS) begin
          slot++;
        end
        if (!p) begin
          exp_en = 1'b0; lock_cnt = 0;
        end else if (t && !exp_en) begin
          if (lock_cnt == LOCK_WORDS - 1) exp_en = 1'b1;
          else lock_cnt++;
        end
      end
      @(negedge clk);
      check(lanes_oe == exp_en, p ? "R6 lanes_oe" : "R5 lanes_oe", lanes_oe, exp_en);
      if (exp_en && slot < SLOTS) begin
        for (int l = 0; l < LANES; l++)
          check(lane_out[l] == cur[l*SLOTS + slot], "R1/R2/R3/R7 lane data",
                lane_out[l], cur[l*SLOTS + slot]);
        check(frame_clk == (slot < 4), "R4 frame clock", frame_clk, (slot < 4));
      end else if (!exp_en) begin
        check(lane_out == '0 && !frame_clk, "R5 lanes quiet",
              {lane_out, frame_clk}, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [WORD_W-1:0] lfsr;
    rst = 1'b1; pwr_n = 1'b0; word_tick = 1'b0; word_in = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!lanes_oe && lane_out == '0 && !frame_clk, "R8 reset state",
          {lanes_oe, lane_out, frame_clk}, 0);

    // powered down frames: R5
    send_word(28'h1234567, -1);
    send_word(28'h7654321, -1);

    // release, lock wait then data: R6, R2, R3, R4, R7
    pwr_n = 1'b1;
    send_word(28'h0000000, -1);
    send_word(28'hFFFFFFF, -1);
    send_word(28'h5555555, -1);
    send_word(28'hAAAAAAA, -1);
    send_word(28'h000007F, -1);
    send_word(28'h0003F80, -1);
    send_word(28'h01FC000, -1);
    send_word(28'hFE00000, -1);
    for (int i = 0; i < WORD_W; i += 3) send_word(28'h1 << i, -1);
    lfsr = 28'h9ABCDEF;
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[26:0], lfsr[27] ^ lfsr[24]};
      send_word(lfsr, -1);
    end

    // powerdown mid-frame, hold down, relock: R5, R6
    send_word(28'h0F1E2D3, 3);
    send_word(28'h3C4B5A6, -1);
    send_word(28'h6978879, -1);
    pwr_n = 1'b1;
    for (int i = 0; i < 8; i++) send_word(28'h0C0FFEE + 28'(i * 28'h111111), -1);

    // reset mid-run: R8 then relock
    do_reset(2);
    for (int i = 0; i < 7; i++) send_word(28'hB00B000 ^ 28'(i << 5), -1);

    @(posedge clk); #1 word_tick = 1'b0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule